// File: doc/BRIEF.md
# Dual-Die Asynchronous SRAM Controller

This block sits between a simple synchronous host port and a byte-wide memory made of two asynchronous SRAM dies of 512K x 8 each. Both dies share the row address lines, the 8-bit data bus and a single active-low output gate. Each die has its own active-low select and its own active-low write strobe. The top bit of the host's 20-bit byte address picks the die. The lower 19 bits go out on the shared row address.

The host raises a request with an address, a write flag and write data. The controller sequences the SRAM pins and answers with a one-cycle done pulse. For reads, the captured byte is returned with that pulse. Every analog timing minimum of the memory becomes a cycle count, and these counts are set by parameters. The defaults suit a 10 ns clock. The data bus is kept as separate output, output-enable and input vectors, so that pad drivers stay outside the block.

Top module: `dual_sram_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, both die selects, both write strobes and the output gate are high (inactive), the bus drive enable is low, done is low and the read data register is zero.
- R2: Host address bit 19 set selects die 1 and clear selects die 0: only that die's select goes low during the access, and host address bits 18..0 appear on the row address.
- R3: At most one die select is low at any time. While the output gate is low, exactly one die is selected and the controller does not drive the bus.
- R4: A read holds the selected die's select low, its write strobe high and the output gate low for exactly RD_CYC cycles (default 3). The byte on the bus in the last of those cycles is returned on the read data port, and done is high in the following cycle.
- R5: During a write the output gate stays high, and the selected die's write strobe stays low for at least WPULSE_CYC cycles (default 2).
- R6: The controller starts driving the bus only after the write strobe has been low for more than WLQZ_CYC cycles (default 1). The bus is driven for at least DSU_CYC cycles (default 2) before the strobe rises.
- R7: In the cycle in which the write strobe rises, the bus is still driven, and the written byte and row address are unchanged from the cycle before.
- R8: Between a read's output gate release and the next write strobe fall there are at least TURN_CYC+1 cycles (default 2) with every select, strobe and gate high. A write strobe stays high for at least GAP_CYC cycles (default 1) before it falls again.
- R9: Done is a single-cycle pulse, with exactly one per accepted request. Request, address, flag and data presented while an access is in progress are ignored: no extra access starts and no other location changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, accepted only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Byte address; bit 19 selects the die |
| host_wdata | input | 8 | Write byte |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Captured read byte |
| mem_addr | output | 19 | Shared row address |
| mem_ce_n | output | 2 | Per-die active-low select |
| mem_we_n | output | 2 | Per-die active-low write strobe |
| mem_oe_n | output | 1 | Shared active-low output gate |
| mem_dq_out | output | 8 | Byte to drive onto the data bus |
| mem_dq_drive | output | 1 | High while the controller drives the bus |
| mem_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
A sequencer stuck in or skipping a state shows up at the pins within the same access. It appears either as a strobe or gate run of the wrong length, counted in cycles, or as a done pulse that never arrives. A wrong die or a stale address register shows up in the first cycle a select goes low. A lost turnaround or early bus drive shows as a pin overlap on the cycle where the write strobe falls. Data-path faults appear as a mismatched byte at the next read of that location. The sweep writes both dies at spread-out row addresses and then reads them back. The reads include read-to-write alternation, so that every transition ordering occurs.

// File: rtl/dsram_pkg.sv
package dsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WZ,
        ST_WDRV,
        ST_WHOLD
    } seq_state_e;

    typedef struct packed {
        logic sel;
        logic wr_strobe;
        logic rd_gate;
        logic drive;
    } pin_phase_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_phase_t phase_of(input seq_state_e s);
        pin_phase_t p;
        p = '0;
        case (s)
            ST_READ:  begin p.sel = 1'b1; p.rd_gate = 1'b1; end
            ST_WZ:    begin p.sel = 1'b1; p.wr_strobe = 1'b1; end
            ST_WDRV:  begin p.sel = 1'b1; p.wr_strobe = 1'b1; p.drive = 1'b1; end
            ST_WHOLD: begin p.drive = 1'b1; end
            default:  p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dsram_timer.sv
module dsram_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len - CW'(1);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign last = (cnt == '0);

    // R4
    load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0));
endmodule

// File: rtl/dsram_die_decode.sv
module dsram_die_decode
    import dsram_pkg::*;
#(
    parameter int DIE_BITS = 1,
    localparam int NDIE = 1 << DIE_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIE_BITS-1:0] die,
    input  pin_phase_t          ph,
    output logic [NDIE-1:0]     ce_n,
    output logic [NDIE-1:0]     we_n
);
    for (genvar g = 0; g < NDIE; g++) begin : g_die
        logic hit;
        assign hit     = (die == DIE_BITS'(g));
        assign ce_n[g] = !(ph.sel && hit);
        assign we_n[g] = !(ph.wr_strobe && hit);
    end

    // R3
    one_die_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n));

    // R2
    strobe_in_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ((~we_n) & ce_n) == '0);
endmodule

// File: rtl/dual_sram_ctrl.sv
module dual_sram_ctrl
    import dsram_pkg::*;
#(
    parameter int DIE_BITS   = 1,
    parameter int ROW_W      = 19,
    parameter int DATA_W     = 8,
    parameter int RD_CYC     = 3,
    parameter int TURN_CYC   = 1,
    parameter int WLQZ_CYC   = 1,
    parameter int WPULSE_CYC = 2,
    parameter int DSU_CYC    = 2,
    parameter int HOLD_CYC   = 1,
    parameter int GAP_CYC    = 1,
    localparam int NDIE = 1 << DIE_BITS,
    localparam int HA_W = ROW_W + DIE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [NDIE-1:0]   mem_ce_n,
    output logic [NDIE-1:0]   mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned DRV_LEN  = max2(DSU_CYC,
                                       (WPULSE_CYC > WLQZ_CYC) ? WPULSE_CYC - WLQZ_CYC : 1);
    localparam int unsigned HOLD_LEN = max2(HOLD_CYC, GAP_CYC);
    localparam int unsigned MAXC     = max2(max2(max2(RD_CYC, TURN_CYC), max2(WLQZ_CYC, DRV_LEN)),
                                       HOLD_LEN);
    localparam int CW = $clog2(MAXC + 1);

    seq_state_e          state, nxt;
    logic                load, last;
    logic [CW-1:0]       len;
    logic [HA_W-1:0]     addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                done_q;
    logic                after_read;
    pin_phase_t          ph;

    dsram_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .len  (len),
        .last (last)
    );

    always_comb begin
        nxt  = state;
        load = 1'b0;
        len  = '0;
        case (state)
            ST_IDLE: if (host_req) begin
                load = 1'b1;
                if (!host_we) begin
                    nxt = ST_READ;  len = CW'(RD_CYC);
                end else if (after_read) begin
                    nxt = ST_TURN;  len = CW'(TURN_CYC);
                end else begin
                    nxt = ST_WZ;    len = CW'(WLQZ_CYC);
                end
            end
            ST_TURN:  if (last) begin nxt = ST_WZ;    load = 1'b1; len = CW'(WLQZ_CYC); end
            ST_READ:  if (last) nxt = ST_IDLE;
            ST_WZ:    if (last) begin nxt = ST_WDRV;  load = 1'b1; len = CW'(DRV_LEN);  end
            ST_WDRV:  if (last) begin nxt = ST_WHOLD; load = 1'b1; len = CW'(HOLD_LEN); end
            ST_WHOLD: if (last) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            data_q     <= '0;
            rdata_q    <= '0;
            done_q     <= 1'b0;
            after_read <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= 1'b0;
            if (state == ST_IDLE && host_req) begin
                addr_q <= host_addr;
                data_q <= host_wdata;
            end
            if (state == ST_READ && last) begin
                rdata_q    <= mem_dq_in;
                done_q     <= 1'b1;
                after_read <= 1'b1;
            end
            if (state == ST_WHOLD && last) begin
                done_q     <= 1'b1;
                after_read <= 1'b0;
            end
        end
    end

    assign ph = phase_of(state);

    dsram_die_decode #(.DIE_BITS(DIE_BITS)) u_dec (
        .clk  (clk),
        .rst  (rst),
        .die  (addr_q[HA_W-1 -: DIE_BITS]),
        .ph   (ph),
        .ce_n (mem_ce_n),
        .we_n (mem_we_n)
    );

    assign mem_addr     = addr_q[ROW_W-1:0];
    assign mem_oe_n     = !ph.rd_gate;
    assign mem_dq_out   = data_q;
    assign mem_dq_drive = ph.drive;
    assign host_done    = done_q;
    assign host_rdata   = rdata_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (mem_ce_n == {NDIE{1'b1}} && mem_we_n == {NDIE{1'b1}} && mem_oe_n
                 && !mem_dq_drive && !host_done));

    // R3
    drive_vs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_drive |-> mem_oe_n);

    // R5
    gate_high_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n != {NDIE{1'b1}}) |-> mem_oe_n);

    // R7
    hold_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(&mem_we_n) |-> (mem_dq_drive && $stable(mem_addr) && $stable(mem_dq_out)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);
endmodule

// File: tb/dual_sram_ctrl_tb.sv
module dual_sram_ctrl_tb;
    localparam int RD_CYC = 3, TURN_CYC = 1, WLQZ_CYC = 1, WPULSE_CYC = 2;
    localparam int DSU_CYC = 2, GAP_CYC = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0;
    logic [19:0] haddr = '0;
    logic [7:0]  hwdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic [18:0] maddr;
    logic [1:0]  ce_n, we_n;
    logic        oe_n, drive;
    logic [7:0]  dq_out, dq_in;

    int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
    logic [7:0] mem [int];
    logic [7:0] refm [int];
    logic [19:0] cur_addr = '0;

    always #2 clk = ~clk;

    dual_sram_ctrl u_dut (
        .clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_addr(haddr),
        .host_wdata(hwdata), .host_done(done), .host_rdata(rdata), .mem_addr(maddr),
        .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq_out(dq_out),
        .mem_dq_drive(drive), .mem_dq_in(dq_in)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] mrd(input int k);
        return mem.exists(k) ? mem[k] : 8'h00;
    endfunction

    always_comb begin
        dq_in = 8'h00;
        if (!oe_n && we_n == 2'b11) begin
            if (ce_n == 2'b10) dq_in = mrd(int'({1'b0, maddr}));
            else if (ce_n == 2'b01) dq_in = mrd(int'({1'b1, maddr}));
        end
    end

    // pin monitor
    int wlow_run = 0, drv_run = 0, whigh_run = 100, allhigh_run = 100, grun = 0, last_grun = 0;
    bit prev_wlow = 0, prev_read = 0, prev_done = 0, act_die = 0;
    logic [18:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;

    always @(negedge clk) begin
        if (!rst) begin
            bit wl;
            wl = (we_n != 2'b11);
            if (!oe_n)  // R3
                chk($countones(~ce_n) == 1 && !drive, "R3", {ce_n, drive}, 0);
            if (ce_n != 2'b11) begin  // R2
                chk(ce_n[cur_addr[19]] == 1'b0 && $countones(~ce_n) == 1 && maddr == cur_addr[18:0],
                    "R2", {ce_n, maddr}, {cur_addr[19], cur_addr[18:0]});
                act_die = (ce_n == 2'b01);
            end
            if (wl) begin
                if (!prev_wlow) begin  // R8
                    chk(whigh_run >= GAP_CYC, "R8", whigh_run, GAP_CYC);
                    if (prev_read) chk(allhigh_run >= TURN_CYC + 1, "R8", allhigh_run, TURN_CYC + 1);
                end
                wlow_run++;
                chk(oe_n, "R5", oe_n, 1);
                if (drive) begin
                    drv_run++;
                    chk(wlow_run > WLQZ_CYC, "R6", wlow_run, WLQZ_CYC + 1);
                end
                whigh_run = 0;
            end else if (prev_wlow) begin
                chk(wlow_run >= WPULSE_CYC, "R5", wlow_run, WPULSE_CYC);
                chk(drv_run >= DSU_CYC, "R6", drv_run, DSU_CYC);
                chk(drive && maddr == prev_addr && dq_out == prev_dq, "R7",
                    {drive, maddr, dq_out}, {1'b1, prev_addr, prev_dq});
                mem[int'({act_die, maddr})] = dq_out;
                wlow_run = 0; drv_run = 0; whigh_run = 1; prev_read = 0;
            end else begin
                whigh_run++;
            end
            if (!oe_n) grun++;
            else if (grun > 0) begin last_grun = grun; grun = 0; prev_read = 1; end
            if (ce_n == 2'b11 && we_n == 2'b11 && oe_n) allhigh_run++;
            else allhigh_run = 0;
            if (done) begin
                done_cnt++;
                chk(!prev_done, "R9", prev_done, 0);
            end
            prev_done = done;
            prev_wlow = wl; prev_addr = maddr; prev_dq = dq_out;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_done();
        int t;
        t = 0;
        while (!done && t < 60) begin @(negedge clk); t++; end
        #1;
        chk(done, "R9", done, 1);
    endtask

    task automatic op(input bit w, input logic [19:0] a, input logic [7:0] d);
        logic [7:0] e;
        @(negedge clk);
        req = 1'b1; we = w; haddr = a; hwdata = d; cur_addr = a;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        if (w) refm[int'(a)] = d;
        else begin
            e = refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
            chk(rdata == e, "R4", rdata, e);
            chk(last_grun == RD_CYC, "R4", last_grun, RD_CYC);
        end
    endtask

    function automatic logic [19:0] mk(input int i);
        return 20'((i % 2) << 19) | 20'((i * 32'h1F3D7) & 32'h7FFFF);
    endfunction

    function automatic logic [7:0] pat(input logic [19:0] a);
        return 8'(((32'(a) * 37) + 11) >> 3);
    endfunction

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // R1
        chk(ce_n == 2'b11 && we_n == 2'b11 && oe_n && !drive && !done && rdata == 8'h00,
            "R1", {ce_n, we_n, oe_n, drive, done, rdata}, {6'b111110, 8'h00});
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ce_n == 2'b11 && we_n == 2'b11 && oe_n && !drive && !done,
            "R1", {ce_n, we_n, oe_n, drive, done}, 5'b11110);

        // write sweep over both dies, then read back (R2 R4 R5 R6 R7)
        for (int i = 0; i < 32; i++) op(1'b1, mk(i), pat(mk(i)));
        for (int i = 0; i < 32; i++) op(1'b0, mk(i), 8'h00);
        // alternate read-then-write for turnaround (R8)
        for (int i = 0; i < 16; i++) begin
            op(1'b0, mk(i), 8'h00);
            op(1'b1, mk(i), ~pat(mk(i)));
        end
        for (int i = 0; i < 16; i++) op(1'b0, mk(i), 8'h00);
        // same row, different dies must not alias (R2)
        op(1'b1, 20'h00055, 8'hC3);
        op(1'b1, 20'h80055, 8'h3C);
        op(1'b0, 20'h00055, 8'h00);
        op(1'b0, 20'h80055, 8'h00);

        // R9: request held and changed while busy is ignored
        d0 = done_cnt;
        @(negedge clk);
        req = 1'b1; we = 1'b1; haddr = mk(3); hwdata = 8'h11; cur_addr = mk(3);
        @(negedge clk);
        haddr = mk(5); hwdata = 8'h99; we = 1'b0;
        while (!done) @(negedge clk);
        req = 1'b0;
        #1;
        refm[int'(mk(3))] = 8'h11;
        repeat (3) @(negedge clk);
        #1;
        chk(done_cnt - d0 == 1, "R9", done_cnt - d0, 1);
        op(1'b0, mk(5), 8'h00);
        op(1'b0, mk(3), 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule